// File: doc/BRIEF.md
# Parallel Display Bus Strobe Sequencer

This block runs single read or write accesses on an 8080-style parallel bus that connects a host to a display controller. On a start request it takes a snapshot of two packed timing words. It then counts ticks from the start of the access and drives chip-select, write-enable and read-enable. Each strobe switches on at its own programmed tick and switches off at its own programmed tick. A tick lasts one system clock, or two when the doubling input is set.

On a write, the block drives the data bus for the whole access. On a read, it samples the bus at a programmed access tick and holds the captured word. A one-clock done pulse marks the end of every access. After an access, chip-select can be kept idle for a programmed number of ticks before the next start is accepted.

Top module: `pbus_strobe_gen`

## Requirements
- R1: While reset is low and directly after it: csOut, weOut, reOut and a0Out are 1, busOe is 0, done is 0, busy is 0 and rdData is 0.
- R2: The timing word onOffWord holds CS-on in bits 3:0, CS-off in 9:4, WE-on in 13:10, WE-off in 19:14, RE-on in 23:20 and RE-off in 29:24. The word is sampled at the clock edge that accepts a start (edge 0). In the clock after edge n (n ≥ 1), each strobe pin reflects tick k = (n-1)/T, where T is the tick length in clocks. A strobe is active when on ≤ k < off and k is below the cycle length.
- R3: With tickDouble set when the start is accepted, T = 2; otherwise T = 1.
- R4: A write access (isRead = 0) drives busOut with wrData and sets busOe for the whole access. reOut stays inactive during a write.
- R5: A read access keeps weOut inactive and busOe at 0. It stores into rdData the busIn value present in the last clock of tick accTime, where accTime is cycleWord bits 27:22. If accTime is not below the read cycle length, rdData is left unchanged.
- R6: The cycle length is cycleWord bits 5:0 for writes and bits 11:6 for reads, with 0 treated as 1. done is high for exactly the one clock after edge cycle×T.
- R7: cycleWord bits 17:12 give a chip-select idle gap G in ticks. busy stays high for the clocks after edges 0 through (cycle+G)×T − 1, and the strobes stay inactive during the gap.
- R8: polCs, polWe, polRe and polA0 set to 1 make the matching pin active high. At 0 (the default) the pin is active low.
- R9: a0Out is active for the whole access when isCmd was 1 at the start, and inactive otherwise.
- R10: Changes to onOffWord, cycleWord or tickDouble while busy have no effect on the running access.
- R11: startReq is ignored while busy is high. A start held high during an access launches nothing until busy has been low for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request an access (taken when idle) |
| isRead | input | 1 | 1 = read access, 0 = write access |
| isCmd | input | 1 | 1 = command access (drives A0 active) |
| wrData | input | DATA_W | Data to drive on a write |
| tickDouble | input | 1 | Tick lasts two clocks when 1 |
| onOffWord | input | 32 | Strobe on/off tick offsets |
| cycleWord | input | 32 | Cycle lengths, CS gap, access time |
| polCs | input | 1 | Chip-select polarity (1 = active high) |
| polWe | input | 1 | Write-enable polarity |
| polRe | input | 1 | Read-enable polarity |
| polA0 | input | 1 | A0 polarity |
| busIn | input | DATA_W | Data bus input for reads |
| csOut | output | 1 | Chip-select pin |
| weOut | output | 1 | Write-enable pin |
| reOut | output | 1 | Read-enable pin |
| a0Out | output | 1 | Command/data select pin |
| busOut | output | DATA_W | Data bus output value |
| busOe | output | 1 | Data bus output enable |
| rdData | output | DATA_W | Captured read data |
| done | output | 1 | One-clock end-of-access pulse |
| busy | output | 1 | Access or CS gap in progress |

## Verification
The bench drives busIn with a value that changes every clock. This exposes a capture taken one clock or one tick off, and a design that samples at the first clock of a doubled tick would store the wrong word. Strobe windows are checked clock by clock at both tick sizes, including an on-offset of zero and an access time at the cycle length, where a wrong design would either capture or end one tick late. Back-to-back starts with a CS gap show up a design that restarts during the gap or re-arms while busy. Scrambling the timing words mid-access shows up a design that reads them live instead of from a snapshot.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 6;
  localparam int CNT_W = OFF_W;

  typedef struct packed {
    logic [ON_W-1:0]  csOn;
    logic [OFF_W-1:0] csOff;
    logic [ON_W-1:0]  weOn;
    logic [OFF_W-1:0] weOff;
    logic [ON_W-1:0]  reOn;
    logic [OFF_W-1:0] reOff;
    logic [OFF_W-1:0] accTime;
  } strobe_cfg_t;

  typedef struct packed {
    logic             launch;
    logic             inAccess;
    logic             inRead;
    logic             inCmd;
    logic [CNT_W-1:0] tickNum;
    logic             tickEnd;
    logic             lastTick;
  } seq_t;

  function automatic strobe_cfg_t unpackStrobe(input logic [31:0] oo, input logic [31:0] cw);
    strobe_cfg_t c;
    c.csOn    = oo[3:0];
    c.csOff   = oo[9:4];
    c.weOn    = oo[13:10];
    c.weOff   = oo[19:14];
    c.reOn    = oo[23:20];
    c.reOff   = oo[29:24];
    c.accTime = cw[27:22];
    return c;
  endfunction
endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        isRead,
  input  logic        isCmd,
  input  logic        tickDouble,
  input  logic [31:0] onOffWord,
  input  logic [31:0] cycleWord,
  output seq_t        seq,
  output strobe_cfg_t cfgQ,
  output logic        busy
);
  typedef enum logic [1:0] {IDLE, ACCESS, RECOVER} state_t;

  state_t           state;
  logic             prePhase;
  logic             dblQ;
  logic             readQ;
  logic             cmdQ;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] wrCycQ;
  logic [CNT_W-1:0] rdCycQ;
  logic [CNT_W-1:0] gapQ;
  logic [CNT_W-1:0] endCount;
  logic             launch;
  logic             tickEnd;
  logic             lastTick;
  logic             unusedBits;

  assign unusedBits = ^{onOffWord[31:30], cycleWord[31:28], cycleWord[21:18]};

  assign launch   = (state == IDLE) && startReq;
  assign tickEnd  = (state != IDLE) && (!dblQ || prePhase);
  assign endCount = (state == ACCESS) ? (readQ ? rdCycQ : wrCycQ) : gapQ;
  assign lastTick = tickEnd && (({1'b0, tickCnt} + 7'd1) >= {1'b0, endCount});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      prePhase <= 1'b0;
      dblQ     <= 1'b0;
      readQ    <= 1'b0;
      cmdQ     <= 1'b0;
      tickCnt  <= '0;
      wrCycQ   <= '0;
      rdCycQ   <= '0;
      gapQ     <= '0;
      cfgQ     <= '0;
    end else if (launch) begin
      state    <= ACCESS;
      prePhase <= 1'b0;
      tickCnt  <= '0;
      dblQ     <= tickDouble;
      readQ    <= isRead;
      cmdQ     <= isCmd;
      wrCycQ   <= cycleWord[5:0];
      rdCycQ   <= cycleWord[11:6];
      gapQ     <= cycleWord[17:12];
      cfgQ     <= unpackStrobe(onOffWord, cycleWord);
    end else if (state != IDLE) begin
      if (dblQ) prePhase <= ~prePhase;
      if (lastTick) begin
        tickCnt  <= '0;
        prePhase <= 1'b0;
        state    <= (state == ACCESS && gapQ != '0) ? RECOVER : IDLE;
      end else if (tickEnd) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  always_comb begin
    seq          = '0;
    seq.launch   = launch;
    seq.inAccess = (state == ACCESS);
    seq.inRead   = readQ;
    seq.inCmd    = cmdQ;
    seq.tickNum  = tickCnt;
    seq.tickEnd  = tickEnd;
    seq.lastTick = lastTick;
  end

  assign busy = (state != IDLE);
endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_t              seq,
  input  strobe_cfg_t       cfgQ,
  input  logic              isRead,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] busIn,
  input  logic [2:0]        polVec,
  input  logic              polA0,
  output logic [2:0]        pinVec,
  output logic              a0Out,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);
  localparam int NSTROBE = 3;

  logic [CNT_W-1:0] onV  [NSTROBE];
  logic [CNT_W-1:0] offV [NSTROBE];
  logic             enV  [NSTROBE];
  logic             cmdAct;

  always_comb begin
    onV[0]  = {{(CNT_W-ON_W){1'b0}}, cfgQ.csOn};
    offV[0] = cfgQ.csOff;
    enV[0]  = 1'b1;
    onV[1]  = {{(CNT_W-ON_W){1'b0}}, cfgQ.weOn};
    offV[1] = cfgQ.weOff;
    enV[1]  = !seq.inRead;
    onV[2]  = {{(CNT_W-ON_W){1'b0}}, cfgQ.reOn};
    offV[2] = cfgQ.reOff;
    enV[2]  = seq.inRead;
  end

  for (genvar i = 0; i < NSTROBE; i++) begin : g_strobe
    logic act;
    assign act = seq.inAccess && enV[i] &&
                 (seq.tickNum >= onV[i]) && (seq.tickNum < offV[i]);
    always_ff @(posedge clk) begin
      if (!rstN) pinVec[i] <= 1'b1;
      else       pinVec[i] <= polVec[i] ? act : ~act;
    end
  end

  assign cmdAct = seq.inAccess && seq.inCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a0Out  <= 1'b1;
      busOe  <= 1'b0;
      busOut <= '0;
      rdData <= '0;
      done   <= 1'b0;
    end else begin
      a0Out <= polA0 ? cmdAct : ~cmdAct;
      busOe <= seq.inAccess && !seq.inRead;
      done  <= seq.inAccess && seq.lastTick;
      if (seq.launch && !isRead) busOut <= wrData;
      if (seq.inAccess && seq.inRead && seq.tickEnd && seq.tickNum == cfgQ.accTime)
        rdData <= busIn;
    end
  end
endmodule

// File: rtl/pbus_strobe_gen.sv
module pbus_strobe_gen
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              isRead,
  input  logic              isCmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickDouble,
  input  logic [31:0]       onOffWord,
  input  logic [31:0]       cycleWord,
  input  logic              polCs,
  input  logic              polWe,
  input  logic              polRe,
  input  logic              polA0,
  input  logic [DATA_W-1:0] busIn,
  output logic              csOut,
  output logic              weOut,
  output logic              reOut,
  output logic              a0Out,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              busy
);
  seq_t        seq;
  strobe_cfg_t cfgQ;
  logic [2:0]  pinVec;

  pbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isRead(isRead), .isCmd(isCmd),
    .tickDouble(tickDouble), .onOffWord(onOffWord), .cycleWord(cycleWord),
    .seq(seq), .cfgQ(cfgQ), .busy(busy)
  );

  pbus_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .seq(seq), .cfgQ(cfgQ), .isRead(isRead),
    .wrData(wrData), .busIn(busIn), .polVec({polRe, polWe, polCs}), .polA0(polA0),
    .pinVec(pinVec), .a0Out(a0Out), .busOut(busOut), .busOe(busOe),
    .rdData(rdData), .done(done)
  );

  assign csOut = pinVec[0];
  assign weOut = pinVec[1];
  assign reOut = pinVec[2];
endmodule

// File: rtl/pbus_strobe_chk.sv
module pbus_strobe_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic csOut,
  input logic reOut,
  input logic busOe,
  input logic polCs,
  input logic polRe
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R6
  done_in_access_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> $past(busy));

  // R4
  no_read_strobe_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && $stable(polRe)) |-> (reOut != polRe));

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busy) && $stable(polCs)) |-> (csOut != polCs));

  // R7
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> $past(busy));
endmodule

bind pbus_strobe_gen pbus_strobe_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .csOut(csOut),
  .reOut(reOut), .busOe(busOe), .polCs(polCs), .polRe(polRe)
);

// File: tb/sim_pbus_strobe_gen.sv
module sim_pbus_strobe_gen;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0, isRead = 1'b0, isCmd = 1'b0, tickDouble = 1'b0;
  logic [DW-1:0] wrData = '0, busIn = '0;
  logic [31:0]   onOffWord = '0, cycleWord = '0;
  logic          polCs = 1'b0, polWe = 1'b0, polRe = 1'b0, polA0 = 1'b0;
  logic          csOut, weOut, reOut, a0Out, busOe, done, busy;
  logic [DW-1:0] busOut, rdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pbus_strobe_gen #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isRead(isRead), .isCmd(isCmd),
    .wrData(wrData), .tickDouble(tickDouble), .onOffWord(onOffWord), .cycleWord(cycleWord),
    .polCs(polCs), .polWe(polWe), .polRe(polRe), .polA0(polA0), .busIn(busIn),
    .csOut(csOut), .weOut(weOut), .reOut(reOut), .a0Out(a0Out), .busOut(busOut),
    .busOe(busOe), .rdData(rdData), .done(done), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mkOnOff(input int cn, cf, wn, wf, rn, rf);
    return {2'b00, 6'(rf), 4'(rn), 6'(wf), 4'(wn), 6'(cf), 4'(cn)};
  endfunction

  function automatic logic [31:0] mkCycle(input int wc, rc, gap, acc);
    return {4'b0000, 6'(acc), 4'b0000, 6'(gap), 6'(rc), 6'(wc)};
  endfunction

  task automatic runAccess(input string tag, input bit rd, input bit cmd, input bit dbl,
                           input bit hold, input bit scramble,
                           input logic [31:0] oo, input logic [31:0] cw, input logic [DW-1:0] data);
    int t, cyc, gap, acc, len, s, k;
    bit inAcc, cs, we, re, a0, oe;
    logic [DW-1:0] prevRd, expRd;
    logic [6:0] exp, got;
    t   = dbl ? 2 : 1;
    cyc = rd ? int'(cw[11:6]) : int'(cw[5:0]);
    if (cyc == 0) cyc = 1;
    gap = int'(cw[17:12]);
    acc = int'(cw[27:22]);
    len = (cyc + gap) * t;
    prevRd = rdData;
    @(negedge clk);
    startReq = 1'b1; isRead = rd; isCmd = cmd; tickDouble = dbl;
    onOffWord = oo; cycleWord = cw; wrData = data;
    @(posedge clk);
    for (int n = 0; n <= len; n++) begin
      @(negedge clk);
      if (n == (hold ? len : 0)) startReq = 1'b0;
      if (scramble && n == 1) begin
        onOffWord = ~oo; cycleWord = ~cw; tickDouble = ~dbl;
      end
      busIn = DW'(16'hC300 + n);
      s = n - 1;
      inAcc = (s >= 0) && (s < cyc * t);
      k = (s >= 0) ? s / t : 0;
      cs = inAcc && k >= int'(oo[3:0])   && k < int'(oo[9:4]);
      we = inAcc && !rd && k >= int'(oo[13:10]) && k < int'(oo[19:14]);
      re = inAcc && rd  && k >= int'(oo[23:20]) && k < int'(oo[29:24]);
      a0 = inAcc && cmd;
      oe = inAcc && !rd;
      exp = {polCs ? cs : !cs, polWe ? we : !we, polRe ? re : !re, polA0 ? a0 : !a0,
             oe, (n == cyc * t), (n < len)};
      got = {csOut, weOut, reOut, a0Out, busOe, done, busy};
      check($sformatf("%s clk%0d", tag, n), {25'd0, got}, {25'd0, exp});
    end
    @(negedge clk);
    check({tag, " R11 no relaunch"}, {29'd0, busy, csOut, done},
          {29'd0, 1'b0, !polCs, 1'b0});
    if (rd) begin
      expRd = (acc < cyc) ? DW'(16'hC300 + (acc + 1) * t - 1) : prevRd;
      check({tag, " R5 capture"}, {16'd0, rdData}, {16'd0, expRd});
    end else begin
      check({tag, " R4 bus data"}, {16'd0, busOut}, {16'd0, data});
    end
  endtask

  task automatic testReset();
    check("R1 reset pins", {25'd0, csOut, weOut, reOut, a0Out, busOe, done, busy},
          {25'd0, 7'b1111000});
    check("R1 reset rdData", {16'd0, rdData}, 32'd0);
  endtask

  task automatic testWriteCmd();
    runAccess("R2 R4 R9 write cmd", 0, 1, 0, 0, 0,
              mkOnOff(1, 6, 2, 5, 0, 1), mkCycle(7, 4, 0, 2), 16'hA55A);
  endtask

  task automatic testReadData();
    runAccess("R5 R6 read", 1, 0, 0, 0, 0,
              mkOnOff(0, 5, 1, 2, 1, 4), mkCycle(3, 6, 0, 3), 16'h0);
  endtask

  task automatic testDoubleTick();
    runAccess("R3 write dbl", 0, 0, 1, 0, 0,
              mkOnOff(1, 4, 1, 3, 0, 1), mkCycle(4, 2, 0, 0), 16'h1234);
    runAccess("R3 R5 read dbl", 1, 1, 1, 0, 0,
              mkOnOff(0, 5, 0, 1, 1, 4), mkCycle(1, 5, 0, 2), 16'h0);
  endtask

  task automatic testGapHold();
    runAccess("R7 R11 gap hold", 0, 0, 0, 1, 0,
              mkOnOff(0, 3, 1, 3, 0, 1), mkCycle(3, 3, 4, 0), 16'hBEEF);
    runAccess("R7 gap dbl", 1, 0, 1, 1, 0,
              mkOnOff(1, 3, 0, 1, 1, 3), mkCycle(2, 3, 2, 2), 16'h0);
  endtask

  task automatic testPolarity();
    polCs = 1'b1; polWe = 1'b1; polRe = 1'b1; polA0 = 1'b1;
    runAccess("R8 pol write", 0, 1, 0, 0, 0,
              mkOnOff(0, 4, 1, 3, 0, 1), mkCycle(4, 2, 1, 0), 16'h5A5A);
    runAccess("R8 pol read", 1, 0, 0, 0, 0,
              mkOnOff(0, 4, 0, 1, 1, 3), mkCycle(2, 4, 0, 1), 16'h0);
    @(negedge clk);
    polCs = 1'b0; polWe = 1'b0; polRe = 1'b0; polA0 = 1'b0;
  endtask

  task automatic testSnapshot();
    runAccess("R10 scramble read", 1, 0, 0, 0, 1,
              mkOnOff(2, 6, 0, 1, 2, 5), mkCycle(2, 7, 1, 4), 16'h0);
  endtask

  task automatic testAccessEdge();
    runAccess("R5 acc at cycle", 1, 0, 0, 0, 0,
              mkOnOff(0, 2, 0, 1, 0, 2), mkCycle(1, 2, 0, 2), 16'h0);
    runAccess("R6 zero cycle", 0, 0, 0, 0, 0,
              mkOnOff(0, 1, 0, 1, 0, 1), mkCycle(0, 0, 0, 0), 16'h7E7E);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteCmd();
    testReadData();
    testDoubleTick();
    testGapHold();
    testPolarity();
    testSnapshot();
    testAccessEdge();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule